// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a 64-word serial EEPROM that has a chip select, a serial clock, a data input and a data output. The host puts a 6-bit word address on `addr` and pulses `start`. The reader then selects the memory and shifts out a 9-bit read frame. The frame is a start bit of one, the read opcode bit pair `10`, and the six address bits, all sent most significant bit first. The reader then clocks in sixteen data bits, most significant first. To finish, it drops chip select and issues one more clock pulse.

Every half period of the serial clock lasts `HALF_CYC` system clocks. With the default of 2000 at 50 MHz, each half period is 40 µs. `busy` is high for the whole transfer. `done` pulses for one cycle at the end, and `rdata` holds the word read from the memory during that cycle.

Top module: `sprom_word_reader`

## Requirements
- R1: After reset, and whenever `busy` is low, `ee_cs`, `ee_sk`, `ee_di` and `done` are all low.
- R2: After a start is accepted, `ee_di` carries the 9-bit frame {1,1,0,addr[5:0]}, bit 8 first. The frame bit is on `ee_di` from the setup half onward. It changes only on a falling edge of `ee_sk`, and it is held for the whole time `ee_sk` is high.
- R3: Each read has one setup half with `ee_sk` low, then 26 clock pulses: 9 for the command, 16 for data and 1 after deselect. Each pulse is one half period high followed by one half period low, and every half period lasts exactly `HALF_CYC` clocks.
- R4: `ee_cs` rises in the cycle after the start is accepted. It stays high through the last data pulse and is low during the final pulse.
- R5: `ee_do` is sampled in the last clock of each data high half, most significant bit first. At `done`, `rdata` equals the 16 sampled bits.
- R6: `ee_di` is low during the 16 data pulses and during the final pulse.
- R7: `busy` is high from the cycle after the accepted start through the `done` cycle. `done` is a single-cycle pulse that comes 53×`HALF_CYC` cycles after the start is accepted.
- R8: The address is captured when the start is accepted. A `start` or an `addr` change while `busy` is high has no effect on timing or on the word returned.
- R9: In the cycle after `done` the reader is idle. A `start` held high across `done` begins a new read one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Read request; accepted only when idle |
| addr | input | 6 | Word address, captured when the request is accepted |
| busy | output | 1 | High while a read is in progress |
| done | output | 1 | One-cycle pulse when `rdata` is valid |
| rdata | output | 16 | Word read from the memory |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench reads addresses 0, 63 and a middle value. It also reads words that are all ones, all zeros and sparse, so a wrong address bit, a wrong shift order or a stuck data bit each give a different word. A memory model in the bench decodes the frame it receives, so a wrong opcode or address returns zero or a different word. One read has a second request and a new address injected while it is running, which shows whether the capture is protected. One pair of reads is started by a request held high across `done`, which exposes any extra or missing idle cycle between reads.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

    // Transfer phases of the reader
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_CMD    = 3'd2,
        PH_DATA   = 3'd3,
        PH_DESEL  = 3'd4,
        PH_FINISH = 3'd5
    } phase_t;

    // Start bit followed by the read opcode
    localparam logic [2:0] READ_PREFIX = 3'b110;

    // Controls from the sequencer to the shift datapath
    typedef struct packed {
        logic load;
        logic shift_cmd;
        logic sample;
    } shift_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sprom_halfclk.sv
module sprom_halfclk #(
    parameter int HALF_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic half_end
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign half_end = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || half_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
    import sprom_pkg::*;
#(
    parameter int CMD_BITS  = 9,
    parameter int DATA_BITS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       half_end,
    output phase_t     phase,
    output logic       sk,
    output logic       cs,
    output logic       run,
    output shift_ctl_t ctl
);
    localparam int BC_W = $clog2(max2(CMD_BITS, DATA_BITS));
    localparam logic [BC_W-1:0] CMD_LAST  = BC_W'(CMD_BITS - 1);
    localparam logic [BC_W-1:0] DATA_LAST = BC_W'(DATA_BITS - 1);

    logic [BC_W-1:0] bitc;

    assign run           = (phase != PH_IDLE) && (phase != PH_FINISH);
    assign ctl.load      = (phase == PH_IDLE) && start;
    assign ctl.shift_cmd = (phase == PH_CMD) && sk && half_end;
    assign ctl.sample    = (phase == PH_DATA) && sk && half_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            sk    <= 1'b0;
            cs    <= 1'b0;
            bitc  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cs    <= 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (half_end) begin
                        phase <= PH_CMD;
                        sk    <= 1'b1;
                        bitc  <= '0;
                    end
                end
                PH_CMD: begin
                    if (half_end) begin
                        if (sk) begin
                            sk <= 1'b0;
                        end else begin
                            sk <= 1'b1;
                            if (bitc == CMD_LAST) begin
                                phase <= PH_DATA;
                                bitc  <= '0;
                            end else begin
                                bitc <= bitc + 1'b1;
                            end
                        end
                    end
                end
                PH_DATA: begin
                    if (half_end) begin
                        if (sk) begin
                            sk <= 1'b0;
                        end else begin
                            sk <= 1'b1;
                            if (bitc == DATA_LAST) begin
                                phase <= PH_DESEL;
                                cs    <= 1'b0;
                            end else begin
                                bitc <= bitc + 1'b1;
                            end
                        end
                    end
                end
                PH_DESEL: begin
                    if (half_end) begin
                        if (sk) begin
                            sk <= 1'b0;
                        end else begin
                            phase <= PH_FINISH;
                        end
                    end
                end
                PH_FINISH: begin
                    phase <= PH_IDLE;
                end
                default: begin
                    phase <= PH_IDLE;
                    sk    <= 1'b0;
                    cs    <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sprom_shift.sv
module sprom_shift
    import sprom_pkg::*;
#(
    parameter int CMD_BITS  = 9,
    parameter int DATA_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  shift_ctl_t           ctl,
    input  logic [CMD_BITS-1:0]  cmd_word,
    input  logic                 do_bit,
    output logic                 di_bit,
    output logic [DATA_BITS-1:0] word
);
    logic [CMD_BITS-1:0] cmd_sr;

    // The serial data output is the top of the command register; it
    // empties to zero after the last frame bit.
    assign di_bit = cmd_sr[CMD_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_sr <= '0;
            word   <= '0;
        end else begin
            if (ctl.load) begin
                cmd_sr <= cmd_word;
            end else if (ctl.shift_cmd) begin
                cmd_sr <= {cmd_sr[CMD_BITS-2:0], 1'b0};
            end
            if (ctl.sample) begin
                word <= {word[DATA_BITS-2:0], do_bit};
            end
        end
    end
endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
    import sprom_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int HALF_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int CMD_BITS = ADDR_W + $bits(READ_PREFIX);

    phase_t     phase;
    logic       half_end;
    logic       run;
    shift_ctl_t ctl;

    sprom_halfclk #(.HALF_CYC(HALF_CYC)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_end (half_end)
    );

    sprom_seq #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .half_end (half_end),
        .phase    (phase),
        .sk       (ee_sk),
        .cs       (ee_cs),
        .run      (run),
        .ctl      (ctl)
    );

    sprom_shift #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cmd_word ({READ_PREFIX, addr}),
        .do_bit   (ee_do),
        .di_bit   (ee_di),
        .word     (rdata)
    );

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_FINISH);
endmodule

// File: rtl/sprom_word_reader_chk.sv
module sprom_word_reader_chk
    import sprom_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   busy,
    input logic   done,
    input logic   ee_cs,
    input logic   ee_sk,
    input logic   ee_di,
    input phase_t phase
);
    // R1: quiet pins while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk && !ee_di && !done));

    // R2: data to the memory never moves while its clock is high
    a_r2_di_stable_high: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> $stable(ee_di));

    // R4: select held through the data pulses
    a_r4_cs_in_data: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> ee_cs);

    // R6: data line low whenever deselected
    a_r6_di_low_desel: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> !ee_di);

    // R7: done is a single pulse inside busy
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R8: busy only ends through done
    a_r8_busy_ends_by_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R3: the clock never runs while in setup or finish
    a_r3_sk_low_edges: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_SETUP) || (phase == PH_FINISH)) |-> !ee_sk);
endmodule

bind sprom_word_reader sprom_word_reader_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .busy  (busy),
    .done  (done),
    .ee_cs (ee_cs),
    .ee_sk (ee_sk),
    .ee_di (ee_di),
    .phase (phase)
);

// File: tb/tb_sprom_word_reader.sv
module tb_sprom_word_reader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam int DONE_T     = 53 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  addr = '0;
    logic        busy, done, ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;
    logic [15:0] rdata;

    int total = 0;
    int bad = 0;
    int finished = 0;
    int done_count = 0;
    int tag_r8 = 0;

    logic [15:0] mem [64];

    sprom_word_reader #(.ADDR_W(6), .DATA_W(16), .HALF_CYC(HALF)) dut (
        .clk(clk), .rst(rst), .start(start), .addr(addr),
        .busy(busy), .done(done), .rdata(rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: decodes the frame, drives data after each rising clock
    int          rc = 0;
    logic [8:0]  rx_cmd = '0;
    always @(posedge ee_sk) begin
        if (!ee_cs) begin
            rc = 0;
            ee_do = 1'b0;
        end else begin
            if (rc < 9) begin
                rx_cmd = {rx_cmd[7:0], ee_di};
            end else if (rc < 25) begin
                if (rx_cmd[8:6] == 3'b110)
                    ee_do = mem[rx_cmd[5:0]][24 - rc];
                else
                    ee_do = 1'b0;
            end
            rc = rc + 1;
        end
    end

    // Reference model: time since the accepted start
    int         t = -1;
    logic [5:0] exp_addr = '0;
    always @(posedge clk) begin
        if (rst) begin
            t = -1;
        end else if (t < 0) begin
            if (start) begin
                t = 0;
                exp_addr = addr;
            end
        end else if (t >= DONE_T) begin
            t = -1;
        end else begin
            t = t + 1;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual=%0h expected=%0h", tag, what, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && finished == 0) begin
            int e_cs, e_sk, e_di, e_busy, e_done, h, k;
            logic [8:0] cmd;
            cmd = {3'b110, exp_addr};
            e_cs = 0; e_sk = 0; e_di = 0; e_busy = 0; e_done = 0;
            if (t >= 0) begin
                e_busy = 1;
                h = t / HALF;
                if (t == DONE_T) begin
                    e_done = 1;
                end else if (h == 0) begin
                    e_cs = 1; e_di = cmd[8];
                end else if (h <= 18) begin
                    k = (h - 1) / 2;
                    e_cs = 1;
                    e_sk = ((h - 1) % 2 == 0) ? 1 : 0;
                    if (e_sk == 1) e_di = cmd[8 - k];
                    else e_di = (k < 8) ? cmd[7 - k] : 0;
                end else if (h <= 50) begin
                    e_cs = 1;
                    e_sk = ((h - 19) % 2 == 0) ? 1 : 0;
                end else if (h == 51) begin
                    e_sk = 1;
                end
            end
            chk("R4", "ee_cs", ee_cs, e_cs);
            chk("R3", "ee_sk", ee_sk, e_sk);
            chk((t >= 0 && t / HALF >= 19) ? "R6" : "R2", "ee_di", ee_di, e_di);
            chk("R7", "busy", busy, e_busy);
            chk("R7", "done", done, e_done);
            if (e_done == 1) begin
                chk(tag_r8 ? "R8" : "R5", "rdata", rdata, mem[exp_addr]);
                done_count++;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_read(input logic [5:0] a, input int glitch);
        @(negedge clk);
        addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch != 0) begin
            tag_r8 = 1;
            repeat (40) @(negedge clk);
            addr = ~a;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
        tag_r8 = 0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h03C5 + 16'h1234);
        mem[5]  = 16'hFFFF;
        mem[6]  = 16'h0000;
        mem[63] = 16'h8001;
        mem[0]  = 16'hA5C3;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset cs", ee_cs, 0);
        chk("R1", "reset sk", ee_sk, 0);
        chk("R1", "reset di", ee_di, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        do_read(6'd0, 0);
        do_read(6'd63, 0);
        do_read(6'd5, 0);
        do_read(6'd6, 0);
        do_read(6'd42, 1);   // R8: request and address change while busy
        do_read(6'd21, 0);

        // R9: request held high across done starts the next read
        @(negedge clk);
        addr = 6'd33;
        start = 1'b1;
        begin
            int seen;
            seen = done_count;
            while (done_count < seen + 2) @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        chk("R9", "idle after back-to-back", busy, 0);
        wait_idle();
        chk("R9", "reads completed", done_count, 8);
        repeat (5) @(negedge clk);
        chk("R1", "idle cs", ee_cs, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (finished == 0) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule